// File: doc/BRIEF.md
# PWM Fault Shutdown Combiner

This block sits between a PWM waveform generator and the gate drivers of a three-phase inverter. Six gate signals come in: the high and low switch of each of three phases. They pass straight through to the drivers until a fault shows up. A fault is an active-low level on a dedicated shutdown pin, or on any general I/O line whose bit is set in a per-line enable register. While a fault is present, or while the captured trip state is held, all six gate outputs are driven low (off).

The gating path is pure combinational logic from the fault inputs to the gate outputs, and an asynchronous set captures the trip. Because of this, protection still works when the system clock has stopped. The captured trip state is passed through a synchronizer. That gives software a readable status bit and a one-cycle interrupt pulse each time a trip occurs. Software releases the outputs by pulsing a clear input. The clear only acts once every enabled fault input has returned high.

A fault line may also feed a separate edge-interrupt unit at the same time. Software can then work out which fault fired. That unit lies outside this block.

Top module: `pwm_fault_trip`

## Requirements
- R1: When `trip_n` is low, or when any `io_in[i]` is low with enable bit `i` set, `gate_out` becomes 6'b000000 without any clock edge.
- R2: While the trip state is held, `gate_out` stays 6'b000000 whatever `gate_in` does. When the trip state is clear and no fault is present, `gate_out` equals `gate_in`.
- R3: The enable register `line_en` resets to all ones. A write (`en_wr` high at a clock edge) loads `en_wdata`. A low level on a line whose enable bit is 0 has no effect on `gate_out`, `tripped` or `trip_irq`.
- R4: Once a fault has set the trip state, the state remains after the fault is released. `tripped` reads 1 from the second clock edge after the set.
- R5: A `clr` pulse sampled while any enabled fault is still low has no effect. A `clr` sampled with no fault present clears the trip state at that edge, and `gate_out` returns to `gate_in`.
- R6: Each trip raises `trip_irq` for exactly one cycle, at the third clock edge after the trip state sets. This applies to both the dedicated pin and the I/O lines, and no other pulses occur.
- R7: A synchronous reset (`rst` high) clears `tripped`, `trip_irq` and the trip state and restores `line_en` to all ones. A fault that is still present at reset keeps the gates off.
- R8: A fault that arrives and leaves while the clock is stopped still turns the gates off and leaves them off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| io_in | input | 12 | General I/O line levels; a low level on an enabled line is a fault |
| trip_n | input | 1 | Dedicated active-low shutdown pin |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 12 | New enable register value |
| clr | input | 1 | Software clear of the trip state |
| gate_in | input | 6 | Gate signals from the PWM generator |
| gate_out | output | 6 | Gate signals to the drivers; all low while tripped |
| line_en | output | 12 | Current enable register value |
| tripped | output | 1 | Synchronized trip status |
| trip_irq | output | 1 | One-cycle trip interrupt pulse |

## Verification
The hardest case to reach from the ports is a trip that is captured and released while the clock is not running. It has to leave the gates off with no edge at all, and then produce exactly one interrupt once the clock comes back. The bench gates its own clock generator, toggles a fault line during the pause, checks `gate_out` with time delays, and queues the interrupt it expects after the clock restarts. A second hard case is a reset applied while a fault is still held low. For that case the bench queues the extra interrupt that follows reset release.

// File: rtl/pft_pkg.sv
package pft_pkg;
  localparam int GATES = 6;
  typedef logic [GATES-1:0] gate_vec_t;
endpackage

// File: rtl/pft_fault_or.sv
module pft_fault_or #(
  parameter int N = 12
) (
  input  logic [N-1:0] lines_n,
  input  logic [N-1:0] en,
  input  logic         pin_n,
  output logic         fault
);
  logic [N-1:0] hit;
  for (genvar i = 0; i < N; i++) begin : g_line
    assign hit[i] = en[i] & ~lines_n[i];
  end
  assign fault = (|hit) | ~pin_n;
endmodule

// File: rtl/pft_trip_latch.sv
module pft_trip_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_async,
  input  logic clr,
  output logic q
);
  // Set is asynchronous and dominant; clear acts only on a clock edge
  // where the set input is already low.
  always_ff @(posedge clk or posedge set_async) begin
    if (set_async)
      q <= 1'b1;
    else if (rst || clr)
      q <= 1'b0;
  end
endmodule

// File: rtl/pft_sync_edge.sv
module pft_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      prev <= 1'b0;
      rise <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], d_async};
      prev <= sh[STAGES-1];
      rise <= sh[STAGES-1] & ~prev;
    end
  end
  assign level = sh[STAGES-1];
endmodule

// File: rtl/pft_gate.sv
module pft_gate
  import pft_pkg::*;
(
  input  gate_vec_t din,
  input  logic      kill,
  output gate_vec_t dout
);
  for (genvar g = 0; g < GATES; g++) begin : g_sw
    assign dout[g] = din[g] & ~kill;
  end
endmodule

// File: rtl/pwm_fault_trip.sv
module pwm_fault_trip
  import pft_pkg::*;
#(
  parameter int N_LINES     = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] io_in,
  input  logic               trip_n,
  input  logic               en_wr,
  input  logic [N_LINES-1:0] en_wdata,
  input  logic               clr,
  input  logic [GATES-1:0]   gate_in,
  output logic [GATES-1:0]   gate_out,
  output logic [N_LINES-1:0] line_en,
  output logic               tripped,
  output logic               trip_irq
);
  localparam logic [N_LINES-1:0] EN_RESET = '1;

  logic fault_any;
  logic trip_q;
  logic kill;

  always_ff @(posedge clk) begin
    if (rst)
      line_en <= EN_RESET;
    else if (en_wr)
      line_en <= en_wdata;
  end

  pft_fault_or #(.N(N_LINES)) u_or (
    .lines_n(io_in),
    .en     (line_en),
    .pin_n  (trip_n),
    .fault  (fault_any)
  );

  pft_trip_latch u_latch (
    .clk      (clk),
    .rst      (rst),
    .set_async(fault_any),
    .clr      (clr),
    .q        (trip_q)
  );

  assign kill = fault_any | trip_q;

  pft_gate u_gate (
    .din (gate_in),
    .kill(kill),
    .dout(gate_out)
  );

  pft_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async(trip_q),
    .level  (tripped),
    .rise   (trip_irq)
  );
endmodule

// File: rtl/pwm_fault_trip_chk.sv
module pwm_fault_trip_chk (
  input logic       clk,
  input logic       rst,
  input logic       fault_any,
  input logic       trip_q,
  input logic       clr,
  input logic [5:0] gate_out,
  input logic       tripped,
  input logic       trip_irq
);
  AST_FAULT_SETS: assert property (@(posedge clk) disable iff (rst)
    fault_any |-> trip_q); // R1
  AST_GATES_OFF: assert property (@(posedge clk) disable iff (rst)
    trip_q |-> gate_out == 6'b0); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (trip_q && !clr) |=> trip_q); // R4
  AST_CLR_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (trip_q && fault_any) |=> trip_q); // R5
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    $rose(tripped) |=> trip_irq); // R6
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    trip_irq |=> !trip_irq); // R6
endmodule

bind pwm_fault_trip pwm_fault_trip_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .fault_any(fault_any),
  .trip_q   (trip_q),
  .clr      (clr),
  .gate_out (gate_out),
  .tripped  (tripped),
  .trip_irq (trip_irq)
);

// File: tb/pwm_fault_trip_bench.sv
module pwm_fault_trip_bench;
  localparam int N = 12;

  logic         clk = 1'b0;
  logic         clk_run = 1'b1;
  logic         rst = 1'b1;
  logic [N-1:0] io_in = '1;
  logic         trip_n = 1'b1;
  logic         en_wr = 1'b0;
  logic [N-1:0] en_wdata = '0;
  logic         clr = 1'b0;
  logic [5:0]   gate_in = 6'h2D;
  logic [5:0]   gate_out;
  logic [N-1:0] line_en;
  logic         tripped;
  logic         trip_irq;

  int checks = 0;
  int fails = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #4 if (clk_run) clk = ~clk;

  pwm_fault_trip u_pwm_fault_trip (
    .clk(clk), .rst(rst), .io_in(io_in), .trip_n(trip_n),
    .en_wr(en_wr), .en_wdata(en_wdata), .clr(clr),
    .gate_in(gate_in), .gate_out(gate_out), .line_en(line_en),
    .tripped(tripped), .trip_irq(trip_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  // Monitor: pops one expected trip per interrupt pulse.
  always begin
    @(posedge clk);
    #2;
    if (!rst && trip_irq) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R6 actual=unexpected_irq expected=none");
      end else begin
        void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    #1600000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    cycles(3);
    rst = 1'b0;
    cycles(2);
    #1;
    // R7 reset state, R3 enable reset value
    check("R7", tripped, 0);
    check("R7", trip_irq, 0);
    check("R2", gate_out, 6'h2D);
    check("R3", line_en, 12'hFFF);

    // I/O line fault: immediate shutdown, latched
    @(negedge clk);
    exp_q.push_back(1);
    io_in[5] = 1'b0;
    #1 check("R1", gate_out, 0);
    cycles(1);
    #1 check("R4", tripped, 0);
    cycles(1);
    #1 check("R4", tripped, 1);
    cycles(4);
    io_in[5] = 1'b1;
    gate_in = 6'h3F;
    #1 check("R4", gate_out, 0);
    check("R2", gate_out, 0);
    pulse_clr();
    #1 check("R5", gate_out, 6'h3F);
    cycles(3);
    #1 check("R5", tripped, 0);

    // Dedicated pin, clear blocked while fault stays low
    @(negedge clk);
    exp_q.push_back(2);
    trip_n = 1'b0;
    #1 check("R1", gate_out, 0);
    cycles(2);
    pulse_clr();
    trip_n = 1'b1;
    cycles(4);
    #1 check("R5", gate_out, 0);
    check("R5", tripped, 1);
    pulse_clr();
    #1 check("R5", gate_out, 6'h3F);
    cycles(4);

    // Disabled line has no effect
    @(negedge clk);
    en_wr = 1'b1;
    en_wdata = 12'hFF7;
    @(negedge clk);
    en_wr = 1'b0;
    #1 check("R3", line_en, 12'hFF7);
    io_in[3] = 1'b0;
    #1 check("R3", gate_out, 6'h3F);
    cycles(6);
    #1 check("R3", tripped, 0);
    io_in[3] = 1'b1;

    // Fault while clock is stopped
    @(negedge clk);
    clk_run = 1'b0;
    #20 io_in[0] = 1'b0;
    #1 check("R8", gate_out, 0);
    #20 io_in[0] = 1'b1;
    #1 check("R8", gate_out, 0);
    exp_q.push_back(3);
    #20 clk_run = 1'b1;
    cycles(6);
    #1 check("R8", tripped, 1);
    pulse_clr();
    #1 check("R5", gate_out, 6'h3F);
    cycles(4);

    // Reset with a fault held low
    @(negedge clk);
    exp_q.push_back(4);
    io_in[7] = 1'b0;
    cycles(6);
    exp_q.push_back(5);
    rst = 1'b1;
    cycles(2);
    #1 check("R7", gate_out, 0);
    check("R7", tripped, 0);
    check("R7", line_en, 12'hFFF);
    rst = 1'b0;
    cycles(6);
    io_in[7] = 1'b1;
    pulse_clr();
    #1 check("R7", gate_out, 6'h3F);
    cycles(8);
    check("R6", exp_q.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule